// File: doc/BRIEF.md
# Two-Bit Cursor Overlay

The block paints a 64-by-64 pointer image over a live pixel stream. Every clock it receives the raster coordinate of the pixel now being produced and that pixel's 24-bit colour. One clock later it returns either that colour unchanged or a colour chosen by the cursor image. The image sits in a local 1024-byte store that holds 64 rows of 16 bytes. Each byte carries four 2-bit pixel codes. The store is loaded through a plain byte write port.

The pointer's top-left corner comes from one packed position word. The raster x field is in the low part of the word and the raster y field is in the high part. A vertical trim value cuts rows from the bottom of the drawn area: only the first 64 minus trim rows of the image appear on screen. Two colour inputs supply the solid cursor colours. An enable input turns the whole overlay off.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held, the output pixel reads zero.
- R2: With the enable low, the output equals the display pixel presented one clock earlier.
- R3: A raster x below the position x, or at position x plus 64 or more, passes the display pixel through.
- R4: The drawn height is 64 minus the trim value. A raster y below the position y, or at position y plus that height or more, passes the display pixel through.
- R5: Inside the window, code 0 outputs cursor colour 0.
- R6: Inside the window, code 1 outputs cursor colour 1.
- R7: Inside the window, code 2 is transparent and outputs the display pixel.
- R8: Inside the window, code 3 outputs the bitwise inverse of the display pixel.
- R9: For image column c (0..63) and image row r, the code is read from byte address r*16 + c/4. Within that byte it occupies bits [2*(c%4)+1 : 2*(c%4)], so the least significant pair is the leftmost pixel.
- R10: The latency from input pixel to output pixel is exactly one clock.
- R11: Position x is read from bits [10:0] of the position word and position y from bits [21:11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| img_we | input | 1 | Cursor image byte write strobe |
| img_addr | input | 10 | Cursor image byte address |
| img_wdata | input | 8 | Cursor image byte data |
| cur_en | input | 1 | Overlay enable |
| cur_pos | input | 22 | Packed position: x in [10:0], y in [21:11] |
| cur_voff | input | 6 | Vertical trim; rows drawn = 64 - trim |
| cur_col0 | input | 24 | Colour for code 0 |
| cur_col1 | input | 24 | Colour for code 1 |
| raster_x | input | 11 | Current raster column |
| raster_y | input | 11 | Current raster row |
| disp_pix | input | 24 | Underlying display pixel |
| pix_out | output | 24 | Composited pixel, one clock later |

## Verification
An error in the window compare shows up as wrong pixels along the cursor's edge columns or at its last drawn row. An error in the image address or the pair select scrambles the pattern inside the window on the very next clock. A pipeline register out of step moves every output by a cycle, so the first checked pixel after a coordinate change already disagrees. The bench loads a pseudo-random image that contains all four codes. It sweeps full rasters around the cursor under several positions, trims and colours, including the corner at the origin and the far right edge.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int XW = 11,
  parameter int YW = 11,
  parameter int PW = 24,
  localparam int CDIM = 64,
  localparam int OW = $clog2(CDIM),
  localparam int AW = $clog2(CDIM * CDIM / 4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             img_we,
  input  logic [AW-1:0]    img_addr,
  input  logic [7:0]       img_wdata,
  input  logic             cur_en,
  input  logic [XW+YW-1:0] cur_pos,
  input  logic [OW-1:0]    cur_voff,
  input  logic [PW-1:0]    cur_col0,
  input  logic [PW-1:0]    cur_col1,
  input  logic [XW-1:0]    raster_x,
  input  logic [YW-1:0]    raster_y,
  input  logic [PW-1:0]    disp_pix,
  output logic [PW-1:0]    pix_out
);

  logic [7:0] img_mem [CDIM*CDIM/4];

  wire [XW-1:0] pos_x = cur_pos[XW-1:0];
  wire [YW-1:0] pos_y = cur_pos[XW+YW-1:XW];
  wire [XW:0] dx = {1'b0, raster_x} - {1'b0, pos_x};
  wire [YW:0] dy = {1'b0, raster_y} - {1'b0, pos_y};
  wire [OW:0] rows = (OW+1)'(CDIM) - {1'b0, cur_voff};

  wire in_x = !dx[XW] && (dx[XW-1:0] < XW'(CDIM));
  wire in_y = !dy[YW] && (dy[YW-1:0] < YW'(rows));
  wire [AW-1:0] rd_addr = {dy[OW-1:0], dx[OW-1:2]};

  logic [7:0]    byte_q;
  logic          hit_q;
  logic [1:0]    sub_q;
  logic [PW-1:0] disp_q, col0_q, col1_q;

  always_ff @(posedge clk) begin
    if (img_we) img_mem[img_addr] <= img_wdata;
    byte_q <= img_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      sub_q  <= '0;
      disp_q <= '0;
      col0_q <= '0;
      col1_q <= '0;
    end else begin
      hit_q  <= cur_en && in_x && in_y;
      sub_q  <= dx[1:0];
      disp_q <= disp_pix;
      col0_q <= cur_col0;
      col1_q <= cur_col1;
    end
  end

  wire [1:0] code = 2'(byte_q >> {sub_q, 1'b0});

  always_comb begin
    pix_out = disp_q;
    if (hit_q) begin
      case (code)
        2'd0: pix_out = col0_q;
        2'd1: pix_out = col1_q;
        2'd2: pix_out = disp_q;
        default: pix_out = ~disp_q;
      endcase
    end
  end

endmodule

// File: rtl/cursor_overlay_checks.sv
module cursor_overlay_checks #(
  parameter int XW = 11,
  parameter int YW = 11,
  parameter int PW = 24,
  parameter int OW = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cur_en,
  input logic [XW+YW-1:0] cur_pos,
  input logic [OW-1:0]    cur_voff,
  input logic [XW-1:0]    raster_x,
  input logic [YW-1:0]    raster_y,
  input logic [PW-1:0]    disp_pix,
  input logic [PW-1:0]    pix_out
);

  wire [XW-1:0] px = cur_pos[XW-1:0];
  wire [YW-1:0] py = cur_pos[XW+YW-1:XW];
  wire left_of = raster_x < px;
  wire above = raster_y < py;
  wire below = (32'(raster_y) >= 32'(py)) &&
               (32'(raster_y) - 32'(py) >= 32'(64) - 32'(cur_voff));

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> pix_out == '0);

  assert_disabled_pass_R2: assert property (@(posedge clk) disable iff (rst)
    !cur_en |=> pix_out == $past(disp_pix));

  assert_left_pass_R3: assert property (@(posedge clk) disable iff (rst)
    left_of |=> pix_out == $past(disp_pix));

  assert_vert_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (above || below) |=> pix_out == $past(disp_pix));

endmodule

bind cursor_overlay cursor_overlay_checks #(.XW(XW), .YW(YW), .PW(PW), .OW(OW)) u_checks (
  .clk(clk), .rst(rst), .cur_en(cur_en), .cur_pos(cur_pos), .cur_voff(cur_voff),
  .raster_x(raster_x), .raster_y(raster_y), .disp_pix(disp_pix), .pix_out(pix_out)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  logic clk = 0, rst = 1;
  logic img_we = 0;
  logic [9:0] img_addr = 0;
  logic [7:0] img_wdata = 0;
  logic cur_en = 0;
  logic [21:0] cur_pos = 0;
  logic [5:0] cur_voff = 0;
  logic [23:0] cur_col0 = 0, cur_col1 = 0;
  logic [10:0] raster_x = 0, raster_y = 0;
  logic [23:0] disp_pix = 0;
  logic [23:0] pix_out;

  int total = 0, bad = 0;
  bit finished = 0;
  bit pend = 0;
  logic [23:0] pend_exp;
  string pend_tag;

  always #4 clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst(rst), .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata),
    .cur_en(cur_en), .cur_pos(cur_pos), .cur_voff(cur_voff), .cur_col0(cur_col0),
    .cur_col1(cur_col1), .raster_x(raster_x), .raster_y(raster_y),
    .disp_pix(disp_pix), .pix_out(pix_out)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + (a >> 4) * 11 + 5);
  endfunction

  function automatic logic [23:0] dp(int x, int y);
    return 24'(x * 7919 + y * 131 + 24'h123456);
  endfunction

  function automatic logic [23:0] expv(int x, int y, int pxx, int pyy, int vo, bit en,
                                       logic [23:0] c0, logic [23:0] c1, output string tag);
    int dx, dy, code;
    logic [23:0] d;
    d = dp(x, y);
    dx = x - pxx;
    dy = y - pyy;
    if (!en) begin tag = "R2/R10"; return d; end
    if (dx < 0 || dx > 63) begin tag = "R3/R11/R10"; return d; end
    if (dy < 0 || dy >= 64 - vo) begin tag = "R4/R11/R10"; return d; end
    code = (pat(dy * 16 + dx / 4) >> (2 * (dx % 4))) & 3;
    case (code)
      0: begin tag = "R5/R9/R10"; return c0; end
      1: begin tag = "R6/R9/R10"; return c1; end
      2: begin tag = "R7/R9/R10"; return d; end
      default: begin tag = "R8/R9/R10"; return ~d; end
    endcase
  endfunction

  task automatic check(logic [23:0] act, logic [23:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(int x, int y, int pxx, int pyy, int vo, bit en,
                      logic [23:0] c0, logic [23:0] c1);
    string t;
    @(negedge clk);
    if (pend) check(pix_out, pend_exp, pend_tag);
    raster_x = 11'(x);
    raster_y = 11'(y);
    disp_pix = dp(x, y);
    cur_en = en;
    cur_pos = {11'(pyy), 11'(pxx)};
    cur_voff = 6'(vo);
    cur_col0 = c0;
    cur_col1 = c1;
    pend_exp = expv(x, y, pxx, pyy, vo, en, c0, c1, t);
    pend_tag = t;
    pend = 1;
  endtask

  task automatic sweep(int pxx, int pyy, int vo, bit en, logic [23:0] c0, logic [23:0] c1);
    for (int y = pyy - 2; y <= pyy + 66 - vo; y++)
      for (int x = pxx - 2; x <= pxx + 65; x++)
        if (x >= 0 && x < 2048 && y >= 0 && y < 2048)
          step(x, y, pxx, pyy, vo, en, c0, c1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pix_out, 24'h0, "R1");
    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      img_we = 1;
      img_addr = 10'(a);
      img_wdata = pat(a);
    end
    @(negedge clk);
    img_we = 0;
    check(pix_out, 24'h0, "R1");
    rst = 0;
    sweep(100, 50, 0, 1, 24'hFF0000, 24'h00FF00);
    sweep(0, 0, 63, 1, 24'h0000FF, 24'hABCDEF);
    sweep(2000, 1990, 17, 1, 24'h112233, 24'h445566);
    sweep(700, 300, 40, 1, 24'h000000, 24'hFFFFFF);
    sweep(100, 50, 0, 0, 24'hFF0000, 24'h00FF00);
    @(negedge clk);
    if (pend) check(pix_out, pend_exp, pend_tag);
    pend = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule